// File: doc/BRIEF.md
# Double-Buffered Eight-Channel Converter Code Register Bank

This block is the digital register front end of an eight-channel voltage-output converter. A host writes it like a memory. It presents a 13-bit data word, a 3-bit channel number, an active-low select and an active-low write strobe, and the word lands in that channel's staging register. A separate active-low load line copies every staging register into its channel's output register together. Several channels can therefore be prepared one at a time and then changed on the same cycle.

An active-low clear line overrides every channel's output code with the offset-binary zero code, 13'h1000, and raises a flag while it is held. Clear does not change either register rank, so when it is released each channel returns to the code held in its output register. All control inputs are sampled on the rising edge of `clk`. A write stays open while select and strobe are both low, and the word captured on the last edge before select rises is the one that remains. Load behaves the same way: output registers follow the staging rank on every edge while load is low and hold while it is high. An asynchronous active-low reset sets both ranks to midscale, 13'h1000.

Top module: `dac_regbank`

## Requirements
- R1: After reset, every channel's output code is 13'h1000 and `clr_active` is 0 when `clr_n` is high.
- R2: On a rising edge with `cs_n` = 0 and `wr_n` = 0, the data word is stored in the staging register selected by `addr`. `addr[2]` is the MSB and `addr[0]` is the LSB.
- R3: When `cs_n` is 1 on an edge, no staging register changes, whatever the value of `wr_n`.
- R4: A write changes only the addressed staging register. The other seven keep their contents.
- R5: After `cs_n` rises, the addressed staging register keeps the last word captured while the write was open, even if `data` then changes.
- R6: On each edge with `ld_n` = 0, every output register takes its channel's staging value. With `ld_n` = 1, every output register holds.
- R7: A write and a load on the same edge carry the new word to that channel's output after that single edge.
- R8: While `clr_n` = 0, every channel's output code is 13'h1000 and `clr_active` is 1, with no clock edge needed.
- R9: Clear changes neither rank. After `clr_n` returns high, each output shows its output register's value, including any loads made during the clear.
- R10: Channel i's code appears on `dac_code[13*i+12 : 13*i]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cs_n | input | 1 | Chip select, active low |
| wr_n | input | 1 | Write strobe, active low |
| addr | input | 3 | Channel number of the staging register |
| data | input | 13 | Offset-binary code to write |
| ld_n | input | 1 | Load of all output registers, active low |
| clr_n | input | 1 | Clear of all outputs to the zero code, active low |
| dac_code | output | 104 | Eight 13-bit output codes, channel 0 in the low bits |
| clr_active | output | 1 | High while clear is applied |

## Verification
The bench holds the write open across several edges while the data bus changes, then raises select while the bus keeps moving. A design that latched on the wrong edge, or kept following the bus, would load a word other than the last one captured. It drives the strobe low with select high to catch a decode that ignores select, and it checks all eight channels after every write to expose address decode faults and swapped channel slices. It also loads during a clear and checks the outputs after release. A clear that wrote the zero code into a register, or that blocked loading, would show the wrong code once clear goes high.

// File: rtl/dac_regbank_pkg.sv
package dac_regbank_pkg;
    localparam int unsigned DEF_CH = 8;
    localparam int unsigned DEF_W  = 13;

    // Offset-binary zero (also midscale) for a given code width
    function automatic logic [31:0] zero_code(input int unsigned w);
        return 32'd1 << (w - 1);
    endfunction
endpackage

// File: rtl/dac_input_bank.sv
module dac_input_bank
    import dac_regbank_pkg::*;
#(
    parameter int unsigned CH = DEF_CH,
    parameter int unsigned W  = DEF_W,
    parameter int unsigned AW = $clog2(CH)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cs_n,
    input  logic                  wr_n,
    input  logic [AW-1:0]         addr,
    input  logic [W-1:0]          data,
    output logic [CH-1:0][W-1:0]  stage_d,
    output logic [CH-1:0][W-1:0]  stage_q
);
    localparam logic [W-1:0] MID = W'(zero_code(W));

    typedef struct packed {
        logic [CH-1:0][W-1:0] regs;
    } stage_t;

    stage_t          st_d, st_q;
    logic [CH-1:0]   sel;

    // One write enable per channel
    for (genvar i = 0; i < CH; i++) begin : g_sel
        assign sel[i] = !cs_n && !wr_n && (addr == AW'(i));
    end

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < CH; i++) begin
            if (sel[i]) st_d.regs[i] = data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{regs: {CH{MID}}};
        else        st_q <= st_d;
    end

    assign stage_d = st_d.regs;
    assign stage_q = st_q.regs;

    // R3
    sel_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> $stable(stage_q));

    // R2
    write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && !wr_n) |=> (stage_q[$past(addr)] == $past(data)));
endmodule

// File: rtl/dac_load_bank.sv
module dac_load_bank
    import dac_regbank_pkg::*;
#(
    parameter int unsigned CH = DEF_CH,
    parameter int unsigned W  = DEF_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  ld_n,
    input  logic [CH-1:0][W-1:0]  src,
    output logic [CH-1:0][W-1:0]  hold_q
);
    localparam logic [W-1:0] MID = W'(zero_code(W));

    typedef struct packed {
        logic [CH-1:0][W-1:0] regs;
    } hold_t;

    hold_t h_d, h_q;

    always_comb begin
        h_d = h_q;
        if (!ld_n) h_d.regs = src;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) h_q <= '{regs: {CH{MID}}};
        else        h_q <= h_d;
    end

    assign hold_q = h_q.regs;

    // R6
    load_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ld_n |=> $stable(hold_q));

    // R6
    load_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ld_n |=> (hold_q == $past(src)));
endmodule

// File: rtl/dac_out_mask.sv
module dac_out_mask
    import dac_regbank_pkg::*;
#(
    parameter int unsigned CH = DEF_CH,
    parameter int unsigned W  = DEF_W
) (
    input  logic                  clr_n,
    input  logic [CH-1:0][W-1:0]  hold_q,
    output logic [CH*W-1:0]       code_flat,
    output logic                  clr_flag
);
    localparam logic [W-1:0] ZERO = W'(zero_code(W));

    for (genvar i = 0; i < CH; i++) begin : g_ch
        assign code_flat[i*W +: W] = clr_n ? hold_q[i] : ZERO;
    end

    assign clr_flag = !clr_n;
endmodule

// File: rtl/dac_regbank.sv
module dac_regbank
    import dac_regbank_pkg::*;
#(
    parameter int unsigned CH = DEF_CH,
    parameter int unsigned W  = DEF_W,
    parameter int unsigned AW = $clog2(CH)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cs_n,
    input  logic            wr_n,
    input  logic [AW-1:0]   addr,
    input  logic [W-1:0]    data,
    input  logic            ld_n,
    input  logic            clr_n,
    output logic [CH*W-1:0] dac_code,
    output logic            clr_active
);
    localparam logic [W-1:0] ZERO = W'(zero_code(W));

    logic [CH-1:0][W-1:0] stage_d, stage_q, hold_q;

    dac_input_bank #(.CH(CH), .W(W), .AW(AW)) u_stage (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wr_n(wr_n),
        .addr(addr), .data(data), .stage_d(stage_d), .stage_q(stage_q)
    );

    // Next staging value feeds the load rank so write+load flows in one edge
    dac_load_bank #(.CH(CH), .W(W)) u_hold (
        .clk(clk), .rst_n(rst_n), .ld_n(ld_n),
        .src(stage_d), .hold_q(hold_q)
    );

    dac_out_mask #(.CH(CH), .W(W)) u_mask (
        .clr_n(clr_n), .hold_q(hold_q),
        .code_flat(dac_code), .clr_flag(clr_active)
    );

    // R8
    clear_forces_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_n |-> (clr_active && (dac_code == {CH{ZERO}})));

    // R9
    clear_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_n |-> (dac_code == hold_q));
endmodule

// File: tb/sim_dac_regbank.sv
module sim_dac_regbank;
    localparam int CH = 8;
    localparam int W  = 13;
    localparam logic [W-1:0] ZERO = 13'h1000;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            cs_n = 1'b1, wr_n = 1'b1, ld_n = 1'b1, clr_n = 1'b1;
    logic [2:0]      addr = '0;
    logic [W-1:0]    data = '0;
    logic [CH*W-1:0] dac_code;
    logic            clr_active;

    int n_chk = 0, n_fail = 0;
    logic [W-1:0] m_stage [CH];
    logic [W-1:0] m_hold  [CH];
    logic         m_clr;

    always #10 clk = ~clk;   // 50 MHz

    dac_regbank u0 (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wr_n(wr_n), .addr(addr),
        .data(data), .ld_n(ld_n), .clr_n(clr_n),
        .dac_code(dac_code), .clr_active(clr_active)
    );

    function automatic logic [W-1:0] exp_code(input int ch);
        return m_clr ? ZERO : m_hold[ch];
    endfunction

    task automatic check_all(input string tag);
        for (int i = 0; i < CH; i++) begin
            n_chk++;
            if (dac_code[i*W +: W] !== exp_code(i)) begin
                n_fail++;
                $display("FAIL %s ch%0d: got %h expected %h", tag, i,
                         dac_code[i*W +: W], exp_code(i));
            end
        end
        n_chk++;
        if (clr_active !== m_clr) begin
            n_fail++;
            $display("FAIL %s clr_active: got %b expected %b", tag, clr_active, m_clr);
        end
    endtask

    // One edge of stimulus, model update, then check after the edge
    task automatic step(input logic c, input logic w, input logic [2:0] a,
                        input logic [W-1:0] d, input logic l, input logic k,
                        input string tag);
        @(negedge clk);
        cs_n = c; wr_n = w; addr = a; data = d; ld_n = l; clr_n = k;
        @(posedge clk);
        if (!c && !w) m_stage[a] = d;
        if (!l) for (int i = 0; i < CH; i++) m_hold[i] = m_stage[i];
        m_clr = !k;
        #1;
        check_all(tag);
    endtask

    initial begin
        #(20 * 150000);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        for (int i = 0; i < CH; i++) begin m_stage[i] = ZERO; m_hold[i] = ZERO; end
        m_clr = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        check_all("R1 reset midscale");
        @(negedge clk); rst_n = 1'b1;

        // R2 / R6: write ch5 with load high, outputs hold
        step(0, 0, 3'd5, 13'h0ABC, 1, 1, "R6 hold while ld_n high");
        step(1, 1, 3'd0, 13'h0000, 0, 1, "R2 R10 load shows ch5");
        // R3: strobe without select
        step(1, 0, 3'd5, 13'h1FFF, 1, 1, "R3 cs_n high");
        step(1, 1, 3'd5, 13'h1FFF, 0, 1, "R3 R4 load after ignored write");
        // R5: open write while bus moves, then select rises with bus moving
        step(0, 0, 3'd2, 13'h0111, 1, 1, "R5 open write");
        step(0, 0, 3'd2, 13'h0222, 1, 1, "R5 open write");
        step(1, 0, 3'd2, 13'h0333, 1, 1, "R5 select raised");
        step(1, 1, 3'd2, 13'h0444, 0, 1, "R5 R4 load keeps last word");
        // R7: write and load on same edge
        step(0, 0, 3'd7, 13'h1555, 0, 1, "R7 pass-through");
        step(0, 0, 3'd0, 13'h0001, 0, 1, "R7 pass-through ch0");
        // R8: clear combinational
        @(negedge clk); clr_n = 1'b0; m_clr = 1'b1; #1;
        check_all("R8 clear immediate");
        // R9: write and load during clear, then release
        step(0, 0, 3'd3, 13'h0777, 1, 0, "R8 clear during write");
        step(1, 1, 3'd3, 13'h0000, 0, 0, "R8 clear during load");
        step(1, 1, 3'd0, 13'h0000, 1, 0, "R9 clear held");
        @(negedge clk); clr_n = 1'b1; m_clr = 1'b0; #1;
        check_all("R9 release restores");
        step(1, 1, 3'd0, 13'h0000, 1, 1, "R9 stored kept");

        // Random mix, all channels checked each edge
        for (int n = 0; n < 400; n++) begin
            logic [31:0] r;
            r = $urandom();
            step(r[0] & r[1], r[2] & r[3], r[6:4], 13'($urandom()),
                 r[7] | r[8], !(r[9] & r[10] & r[11]), "R2 R4 R6 random");
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule